// File: doc/BRIEF.md
# AEGIS-128 State Update Core

This block keeps the 640-bit working state of the AEGIS-128 authenticated cipher as five 128-bit words, word 0 to word 4. Every state update runs five keyless AES rounds side by side, one per word, and combines their results with the old words and a 128-bit message word through an XOR network. One full update completes in a single clock cycle.

Two commands drive the block. The setup command captures a 128-bit key and a 128-bit nonce, loads the state from them and two fixed 128-bit constants, and then runs ten updates on its own. The absorb command applies one update with a caller-supplied message word. A busy flag marks the setup sequence, a one-cycle done pulse marks the end of each command, and the whole state is always visible on a flat read port. A surrounding engine uses the port to form keystream and tags.

Top module: `aegis_state_core`

## Requirements
- R1: After reset, every bit of `state_o` is 0, and `busy_o` and `done_o` are 0.
- R2: When `busy_o` is low and `absorb_req` is high with `init_req` low, the next clock edge applies one update with M = `msg_i`: W0' = W0 ^ A(W4) ^ M, W1' = W1 ^ A(W0), W2' = W2 ^ A(W1), W3' = W3 ^ A(W2), W4' = W4 ^ A(W3), all computed from the old words. In the cycle after that edge `done_o` is 1 and `busy_o` stays 0. Word n sits at `state_o[128n+127:128n]`, and byte j of a word at bits [8j+7:8j].
- R3: A(x) is one AES round with an all-zero round key. Byte i of the word is row i mod 4, column i div 4. Output byte i of the byte shuffle takes input byte [0,5,10,15,4,9,14,3,8,13,2,7,12,1,6,11][i]. Each byte then goes through the AES substitution box (S(0)=0x63). Each column is then multiplied by the circulant matrix rows (2,3,1,1), where doubling is a left shift that XORs in 0x1b when bit 7 was set. So A(0) has every byte equal to 0x63.
- R4: When `busy_o` is low and `init_req` is high, the next edge loads W0 = K^N, W1 = C1, W2 = C0, W3 = K^C0, W4 = K^C1, with K = `key_i` and N = `iv_i`. C0 is the byte list 00 01 01 02 03 05 08 0d 15 22 37 59 90 e9 79 62, and C1 is db 3d 18 55 6d c2 2f f1 20 11 31 42 73 b5 28 dd, both listed from byte 0 up. `busy_o` is 1 in the following cycle.
- R5: After loading, setup runs ten updates on consecutive edges. Update 1, 3, 5, 7 and 9 uses M = K and the even-numbered ones use M = K^N. K and N are the values captured on the load edge, and later changes on `key_i` or `iv_i` have no effect.
- R6: `busy_o` stays high for exactly ten cycles after the load edge. `done_o` is low while `busy_o` is high and is 1 in the single cycle after `busy_o` falls, when `state_o` holds the final setup state.
- R7: `absorb_req` while `busy_o` is high is ignored: the setup result and its timing are unchanged.
- R8: `init_req` while `busy_o` is high is ignored: the running setup is neither restarted nor extended.
- R9: When `init_req` and `absorb_req` are both high while idle, setup wins and `msg_i` is not applied.
- R10: While idle with no request, `state_o` holds its value and `done_o` is 0 one cycle after any command's pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| init_req | input | 1 | Start key/nonce setup (taken only when idle) |
| absorb_req | input | 1 | Apply one update with `msg_i` (taken only when idle) |
| key_i | input | 128 | Key, captured on the setup load edge |
| iv_i | input | 128 | Nonce, captured on the setup load edge |
| msg_i | input | 128 | Message word for an absorb |
| busy_o | output | 1 | High while the setup updates run |
| done_o | output | 1 | One-cycle pulse after a command completes |
| state_o | output | 640 | All five state words, word 0 in the low bits |

## Verification
The bench builds the block with its defaults, a 128-bit word and five setup pairs, so the setup sequence is the full ten updates and the checker's busy-length window is ten. With those values, known-answer cases (an absorb of zero from the reset state giving all-0x63 words) sit beside random key, nonce and message runs checked against a bench model. The same runs cover requests injected in the middle of setup, key and nonce inputs that change during setup, a simultaneous setup and absorb request, and back-to-back absorbs.

// File: rtl/aegis_pkg.sv
package aegis_pkg;

   localparam int WORD_BITS = 128;
   localparam int STATE_WORDS = 5;

   // Fixed setup constants, byte 0 in bits [7:0]
   localparam logic [WORD_BITS-1:0] FIB_CONST_A =
      128'h6279e990_59372215_0d080503_02010100;
   localparam logic [WORD_BITS-1:0] FIB_CONST_B =
      128'hdd28b573_42311120_f12fc26d_55183ddb;

   function automatic logic [7:0] gf_dbl(input logic [7:0] a);
      return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
   endfunction

   function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] acc;
      logic [7:0] t;
      acc = 8'h00;
      t   = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) acc = acc ^ t;
         t = gf_dbl(t);
      end
      return acc;
   endfunction

   function automatic logic [7:0] rotl8(input logic [7:0] a, input int n);
      return (a << n) | (a >> (8 - n));
   endfunction

   // Substitution box: field inverse (x^254) followed by the affine map
   function automatic logic [7:0] sub_byte(input logic [7:0] x);
      logic [7:0] pw;
      logic [7:0] inv;
      pw  = gf_mul(x, x);
      inv = pw;
      for (int k = 2; k < 8; k++) begin
         pw  = gf_mul(pw, pw);
         inv = gf_mul(inv, pw);
      end
      return inv ^ rotl8(inv, 1) ^ rotl8(inv, 2) ^ rotl8(inv, 3) ^ rotl8(inv, 4) ^ 8'h63;
   endfunction

endpackage

// File: rtl/aegis_aes_round.sv
module aegis_aes_round
   import aegis_pkg::*;
#(
   parameter int WORD_W = 128
) (
   input  logic [WORD_W-1:0] din,
   output logic [WORD_W-1:0] dout
);
   localparam int NBYTES = WORD_W / 8;
   localparam int NCOLS  = NBYTES / 4;

   for (genvar c = 0; c < NCOLS; c++) begin : g_col
      logic [7:0] sb [4];
      // row shuffle then substitution
      for (genvar r = 0; r < 4; r++) begin : g_sub
         assign sb[r] = sub_byte(din[8*(4*((c + r) % NCOLS) + r) +: 8]);
      end
      // column mixing: 2*a_r ^ 3*a_(r+1) ^ a_(r+2) ^ a_(r+3)
      for (genvar r = 0; r < 4; r++) begin : g_mix
         assign dout[8*(4*c + r) +: 8] = gf_dbl(sb[r] ^ sb[(r + 1) % 4])
                                       ^ sb[(r + 1) % 4] ^ sb[(r + 2) % 4] ^ sb[(r + 3) % 4];
      end
   end
endmodule

// File: rtl/aegis_update.sv
module aegis_update
   import aegis_pkg::*;
#(
   parameter int WORD_W = 128
) (
   input  logic [STATE_WORDS*WORD_W-1:0] cur_state,
   input  logic [WORD_W-1:0]             msg_word,
   output logic [STATE_WORDS*WORD_W-1:0] nxt_state
);
   logic [WORD_W-1:0] rnd [STATE_WORDS];

   for (genvar w = 0; w < STATE_WORDS; w++) begin : g_word
      aegis_aes_round #(.WORD_W(WORD_W)) round_i (
         .din  (cur_state[w*WORD_W +: WORD_W]),
         .dout (rnd[w])
      );
      if (w == 0) begin : g_head
         assign nxt_state[0 +: WORD_W] = cur_state[0 +: WORD_W]
                                       ^ rnd[STATE_WORDS-1] ^ msg_word;
      end else begin : g_chain
         assign nxt_state[w*WORD_W +: WORD_W] = cur_state[w*WORD_W +: WORD_W] ^ rnd[w-1];
      end
   end
endmodule

// File: rtl/aegis_ctrl.sv
module aegis_ctrl #(
   parameter int INIT_PAIRS = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic init_req,
   input  logic absorb_req,
   output logic load_en,
   output logic step_en,
   output logic absorb_en,
   output logic use_kiv,
   output logic busy,
   output logic done
);
   localparam int STEPS = 2 * INIT_PAIRS;
   localparam int CW    = $clog2(STEPS + 1);

   logic [CW-1:0] step_q;
   logic          busy_q;
   logic          done_q;
   logic          last_step;

   assign load_en   = !busy_q && init_req;
   assign absorb_en = !busy_q && absorb_req && !init_req;
   assign step_en   = busy_q;
   assign use_kiv   = step_q[0];
   assign last_step = (step_q == CW'(STEPS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         step_q <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= absorb_en || (busy_q && last_step);
         if (load_en) begin
            busy_q <= 1'b1;
            step_q <= '0;
         end else if (busy_q) begin
            step_q <= step_q + 1'b1;
            if (last_step) busy_q <= 1'b0;
         end
      end
   end

   assign busy = busy_q;
   assign done = done_q;
endmodule

// File: rtl/aegis_state_core.sv
module aegis_state_core
   import aegis_pkg::*;
#(
   parameter int WORD_W     = 128,
   parameter int INIT_PAIRS = 5
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          init_req,
   input  logic                          absorb_req,
   input  logic [WORD_W-1:0]             key_i,
   input  logic [WORD_W-1:0]             iv_i,
   input  logic [WORD_W-1:0]             msg_i,
   output logic                          busy_o,
   output logic                          done_o,
   output logic [STATE_WORDS*WORD_W-1:0] state_o
);
   localparam int STATE_W = STATE_WORDS * WORD_W;

   if (WORD_W != WORD_BITS) begin : g_bad_width
      $error("aegis_state_core: WORD_W must be 128");
   end
   if (INIT_PAIRS < 1) begin : g_bad_pairs
      $error("aegis_state_core: INIT_PAIRS must be at least 1");
   end

   logic               load_en, step_en, absorb_en, use_kiv;
   logic [STATE_W-1:0] state_q, upd_next, load_val;
   logic [WORD_W-1:0]  key_q, kiv_q, upd_msg;

   aegis_ctrl #(.INIT_PAIRS(INIT_PAIRS)) ctrl_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .init_req   (init_req),
      .absorb_req (absorb_req),
      .load_en    (load_en),
      .step_en    (step_en),
      .absorb_en  (absorb_en),
      .use_kiv    (use_kiv),
      .busy       (busy_o),
      .done       (done_o)
   );

   assign upd_msg  = step_en ? (use_kiv ? kiv_q : key_q) : msg_i;
   assign load_val = {key_i ^ FIB_CONST_B, key_i ^ FIB_CONST_A,
                      FIB_CONST_A, FIB_CONST_B, key_i ^ iv_i};

   aegis_update #(.WORD_W(WORD_W)) upd_i (
      .cur_state (state_q),
      .msg_word  (upd_msg),
      .nxt_state (upd_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= '0;
         key_q   <= '0;
         kiv_q   <= '0;
      end else if (load_en) begin
         state_q <= load_val;
         key_q   <= key_i;
         kiv_q   <= key_i ^ iv_i;
      end else if (step_en || absorb_en) begin
         state_q <= upd_next;
      end
   end

   assign state_o = state_q;
endmodule

// File: rtl/aegis_state_core_chk.sv
module aegis_state_core_chk #(
   parameter int WORD_W     = 128,
   parameter int INIT_PAIRS = 5
) (
   input logic                clk,
   input logic                rst_n,
   input logic                init_req,
   input logic                absorb_req,
   input logic                busy_o,
   input logic                done_o,
   input logic [5*WORD_W-1:0] state_o
);
   localparam int STEPS = 2 * INIT_PAIRS;
   localparam int LW    = $clog2(STEPS + 1);

   logic [LW-1:0] run_len;

   always_ff @(posedge clk) begin
      if (!rst_n)      run_len <= '0;
      else if (busy_o) run_len <= run_len + 1'b1;
      else             run_len <= '0;
   end

   a_r6_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (int'(run_len) < STEPS));

   a_r6_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (done_o && ($past(run_len) == LW'(STEPS - 1))));

   a_r6_no_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !done_o);

   a_r8_init_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && init_req) |=> busy_o);

   a_r2_absorb_done: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && absorb_req && !init_req) |=> (done_o && !busy_o));

   a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !init_req && !absorb_req) |=> ($stable(state_o) && !done_o));
endmodule

bind aegis_state_core aegis_state_core_chk #(.WORD_W(WORD_W), .INIT_PAIRS(INIT_PAIRS)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .init_req   (init_req),
   .absorb_req (absorb_req),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .state_o    (state_o)
);

// File: tb/aegis_state_core_tb_top.sv
`timescale 1ns/1ps
module aegis_state_core_tb_top;
   localparam int STEPS = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         init_req = 1'b0;
   logic         absorb_req = 1'b0;
   logic [127:0] key_i = '0;
   logic [127:0] iv_i = '0;
   logic [127:0] msg_i = '0;
   logic         busy_o, done_o;
   logic [639:0] state_o;

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 0;

   logic [7:0] sbx [256];
   logic [639:0] model;

   always #10 clk = ~clk;

   aegis_state_core dut_i (
      .clk(clk), .rst_n(rst_n), .init_req(init_req), .absorb_req(absorb_req),
      .key_i(key_i), .iv_i(iv_i), .msg_i(msg_i),
      .busy_o(busy_o), .done_o(done_o), .state_o(state_o)
   );

   function automatic logic [7:0] m2(input logic [7:0] a);
      return a[7] ? ((a << 1) ^ 8'h1b) : (a << 1);
   endfunction

   // substitution table from exp/log over generator 3, then bitwise affine
   task automatic build_sbox();
      logic [7:0] ex [256];
      int lg [256];
      logic [7:0] p;
      p = 8'h01;
      for (int i = 0; i < 255; i++) begin
         ex[i] = p;
         lg[p] = i;
         p = p ^ m2(p);
      end
      for (int x = 0; x < 256; x++) begin
         logic [7:0] b, s;
         b = (x == 0) ? 8'h00 : ex[(255 - lg[x]) % 255];
         for (int i = 0; i < 8; i++)
            s[i] = b[i] ^ b[(i+4)%8] ^ b[(i+5)%8] ^ b[(i+6)%8] ^ b[(i+7)%8] ^ ((8'h63 >> i) & 1'b1);
         sbx[x] = s;
      end
   endtask

   function automatic logic [127:0] ref_round(input logic [127:0] x);
      int perm [16] = '{0,5,10,15,4,9,14,3,8,13,2,7,12,1,6,11};
      logic [7:0] t [16];
      logic [127:0] y;
      for (int i = 0; i < 16; i++) t[i] = sbx[x[8*perm[i] +: 8]];
      for (int c = 0; c < 4; c++) begin
         logic [7:0] a0, a1, a2, a3;
         a0 = t[4*c]; a1 = t[4*c+1]; a2 = t[4*c+2]; a3 = t[4*c+3];
         y[8*(4*c)   +: 8] = m2(a0) ^ m2(a1) ^ a1 ^ a2 ^ a3;
         y[8*(4*c+1) +: 8] = a0 ^ m2(a1) ^ m2(a2) ^ a2 ^ a3;
         y[8*(4*c+2) +: 8] = a0 ^ a1 ^ m2(a2) ^ m2(a3) ^ a3;
         y[8*(4*c+3) +: 8] = m2(a0) ^ a0 ^ a1 ^ a2 ^ m2(a3);
      end
      return y;
   endfunction

   function automatic logic [639:0] ref_update(input logic [639:0] s, input logic [127:0] m);
      logic [639:0] n;
      n[0   +: 128] = s[0   +: 128] ^ ref_round(s[512 +: 128]) ^ m;
      n[128 +: 128] = s[128 +: 128] ^ ref_round(s[0   +: 128]);
      n[256 +: 128] = s[256 +: 128] ^ ref_round(s[128 +: 128]);
      n[384 +: 128] = s[384 +: 128] ^ ref_round(s[256 +: 128]);
      n[512 +: 128] = s[512 +: 128] ^ ref_round(s[384 +: 128]);
      return n;
   endfunction

   function automatic logic [127:0] bytes_le(input logic [7:0] b [16]);
      logic [127:0] w;
      for (int i = 0; i < 16; i++) w[8*i +: 8] = b[i];
      return w;
   endfunction

   function automatic logic [639:0] ref_load(input logic [127:0] k, input logic [127:0] n);
      logic [7:0] c0b [16] = '{8'h00,8'h01,8'h01,8'h02,8'h03,8'h05,8'h08,8'h0d,
                               8'h15,8'h22,8'h37,8'h59,8'h90,8'he9,8'h79,8'h62};
      logic [7:0] c1b [16] = '{8'hdb,8'h3d,8'h18,8'h55,8'h6d,8'hc2,8'h2f,8'hf1,
                               8'h20,8'h11,8'h31,8'h42,8'h73,8'hb5,8'h28,8'hdd};
      logic [127:0] c0, c1;
      c0 = bytes_le(c0b);
      c1 = bytes_le(c1b);
      return {k ^ c1, k ^ c0, c0, c1, k ^ n};
   endfunction

   function automatic logic [127:0] rnd128();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   task automatic chk_bit(input string req, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0b expected %0b", req, act, exp);
      end
   endtask

   task automatic chk_state(input string req, input logic [639:0] exp);
      n_checks++;
      if (state_o !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, state_o, exp);
      end
   endtask

   // R2: one absorb while idle
   task automatic do_absorb(input logic [127:0] m);
      @(negedge clk);
      msg_i = m; absorb_req = 1'b1;
      @(negedge clk);
      absorb_req = 1'b0; msg_i = rnd128();
      model = ref_update(model, m);
      chk_state("R2 absorb state", model);
      chk_bit("R2 absorb done", done_o, 1'b1);
      chk_bit("R2 absorb busy low", busy_o, 1'b0);
   endtask

   // R4/R5/R6, with optional disturbance for R7/R8 and simultaneous absorb for R9
   task automatic do_init(input logic [127:0] k, input logic [127:0] n,
                          input bit disturb, input bit with_absorb);
      int busy_cnt;
      @(negedge clk);
      key_i = k; iv_i = n; init_req = 1'b1;
      absorb_req = with_absorb; msg_i = rnd128();
      @(negedge clk);
      init_req = 1'b0; absorb_req = 1'b0;
      model = ref_load(k, n);
      if (with_absorb) chk_state("R9 setup wins over absorb", model);
      else             chk_state("R4 load values", model);
      chk_bit("R4 busy after load", busy_o, 1'b1);
      busy_cnt = 0;
      for (int s = 1; s <= STEPS; s++) begin
         if (busy_o) busy_cnt++;
         if (disturb && s == 3) begin
            absorb_req = 1'b1; init_req = 1'b1;
            msg_i = rnd128(); key_i = rnd128(); iv_i = rnd128();
         end
         if (disturb && s == 6) begin
            key_i = rnd128(); iv_i = rnd128();
         end
         @(negedge clk);
         absorb_req = 1'b0; init_req = 1'b0;
         model = ref_update(model, (s % 2 == 1) ? k : (k ^ n));
         if (s < STEPS && done_o !== 1'b0) chk_bit("R6 no done while busy", done_o, 1'b0);
      end
      chk_bit("R6 busy length ten", (busy_cnt == STEPS) && !busy_o, 1'b1);
      chk_bit("R6 done at end", done_o, 1'b1);
      if (disturb) chk_state("R7 R8 requests during setup ignored, R5 key captured", model);
      else         chk_state("R5 setup result", model);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++; n_checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'h5eed_a3c1));
      build_sbox();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk_state("R1 reset state", '0);
      chk_bit("R1 reset busy", busy_o, 1'b0);
      chk_bit("R1 reset done", done_o, 1'b0);
      model = '0;

      // R3: absorb of zero from zero state gives 0x63 in every byte
      do_absorb('0);
      chk_state("R3 round of zero word", {80{8'h63}});
      // R10: idle hold and done drops
      @(negedge clk);
      chk_state("R10 idle hold", model);
      chk_bit("R10 done one cycle", done_o, 1'b0);

      // R2: random absorbs, some back to back
      for (int i = 0; i < 8; i++) do_absorb(rnd128());
      @(negedge clk);
      chk_bit("R10 done clears after absorbs", done_o, 1'b0);

      // directed setups
      do_init('0, '0, 1'b0, 1'b0);
      do_init({128{1'b1}}, {128{1'b1}}, 1'b1, 1'b0);
      do_init(rnd128(), rnd128(), 1'b0, 1'b1);   // R9

      // random mix
      for (int j = 0; j < 30; j++) begin
         do_init(rnd128(), rnd128(), ($urandom % 2) == 1, ($urandom % 4) == 0);
         for (int a = 0; a < int'($urandom % 4); a++) do_absorb(rnd128());
         repeat ($urandom % 3) @(negedge clk);
         chk_state("R10 hold between commands", model);
      end

      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule